// File: doc/BRIEF.md
# Debug Byte FIFO Register Interface

This block sits on the console side of a pair of byte FIFOs. One FIFO carries bytes from the host to the console, the other carries bytes from the console to the host. Console software reaches them over a simple 32-bit register bus. A single byte can be moved through dedicated registers. Four bytes at a time can be moved through two memory windows, and those windows only answer while an enable bit in the control register is set. A status register reports both fill levels and accepts flush strobes. The host end of each FIFO is exposed as a plain byte push and byte pop.

Every bus access is a one-cycle request strobe carrying address, write flag and write data. The block acknowledges it one cycle later, and read data is valid in the acknowledge cycle. Pops and pushes caused by an access take effect at the same clock edge that registers the answer. With default parameters the read window sits at 0x0000–0x03FF, the write window at 0x0800–0x0BFF and the registers at 0x1000 (offsets below are relative to it). The FIFOs hold 1024 bytes each.

Top module: `dbg_fifo_regif`

## Requirements
- R1: For every cycle with `req_i` high, `ack_o` is high in the next cycle and low otherwise. A read of an unmapped address, or of any address whose bits 1:0 are not 00, returns 0 and changes no state.
- R2: The control register at offset 0x00 holds bits 5:0, which are read/write and reset to 0x01. Bits 31:6 read as 0.
- R3: Control bit 5 enables the two windows. While it is 0, a window read returns 0 without popping, and a window write pushes nothing.
- R4: A read at offset 0x08 pops one byte from the host-to-console FIFO and returns it in bits 7:0. Bits 31:8 read as 0.
- R5: A write at offset 0x0C pushes `wdata_i[7:0]` into the console-to-host FIFO, and bits 31:8 are ignored. A read of offset 0x0C returns 0 and pops nothing.
- R6: A read of the status register at offset 0x10 returns the console-to-host byte count in bits 21:11 and the host-to-console byte count in bits 10:0. Bits 31:22 read as 0.
- R7: A status write with bit 23 set empties the console-to-host FIFO, and one with bit 22 set empties the host-to-console FIFO. A 0 in either bit leaves that FIFO unchanged.
- R8: A read inside the read window pops up to four bytes. The first byte popped is in bits 31:24 and the last is in bits 7:0.
- R9: A write inside the write window pushes `wdata_i[31:24]` first, then [23:16], then [15:8], then [7:0].
- R10: A pop from an empty FIFO returns 0x00 and leaves the count unchanged. A word read that finds fewer than four bytes fills the missing low-order byte positions with 0.
- R11: A push to a full FIFO is dropped, and a count never exceeds the depth. A word write that finds fewer than four free places keeps only its leading bytes.
- R12: `h2c_push_i` adds `h2c_byte_i` to the host-to-console FIFO. `c2h_byte_o` shows the oldest console-to-host byte, or 0 when that FIFO is empty, and `c2h_pop_i` removes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | One-cycle access strobe |
| we_i | input | 1 | 1 = write access |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | 32 | Write data |
| ack_o | output | 1 | Access answered, one cycle after `req_i` |
| rdata_o | output | 32 | Read data, valid with `ack_o` |
| h2c_push_i | input | 1 | Host pushes one byte |
| h2c_byte_i | input | 8 | Byte pushed by the host |
| c2h_pop_i | input | 1 | Host removes one byte |
| c2h_byte_o | output | 8 | Oldest byte waiting for the host |

## Verification
The bench builds the block with a FIFO depth of 16 and default addresses. At that depth every fill level from empty to full, and one past full, can be swept within a short run. The sweep covers each possible remainder of a word read (one to three leftover bytes), so zero filling can be checked. It also covers word writes that overrun the free space part-way through a word, so the kept leading bytes can be checked. The 11-bit count fields are still checked against counts that are narrower than the field.

// File: rtl/dbgf_pkg.sv
package dbgf_pkg;

   // access kinds produced by the address decoder
   typedef enum logic [2:0] {
      AK_NONE,
      AK_CTRL,
      AK_RXB,
      AK_TXB,
      AK_STAT,
      AK_RXW,
      AK_TXW
   } acc_kind_e;

   localparam int WORD_BYTES = 4;
   localparam int CNT_FW     = 11;   // width of each count field in the status word

   // register offsets inside the register block
   localparam logic [4:0] OFF_CTRL = 5'h00;
   localparam logic [4:0] OFF_RXB  = 5'h08;
   localparam logic [4:0] OFF_TXB  = 5'h0C;
   localparam logic [4:0] OFF_STAT = 5'h10;

   // bit positions that software relies on
   localparam int CTRL_W       = 6;
   localparam int EN_BIT       = 5;
   localparam int FLUSH_C2H    = 23;
   localparam int FLUSH_H2C    = 22;
   localparam int C2H_CNT_LSB  = 11;

endpackage

// File: rtl/dbgf_decode.sv
module dbgf_decode
   import dbgf_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int REG_BASE  = 'h1000,
   parameter int RXW_BASE  = 'h0000,
   parameter int TXW_BASE  = 'h0800,
   parameter int WIN_BYTES = 1024
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              win_en_i,
   output acc_kind_e         kind_o
);

   localparam int AW1 = ADDR_W + 1;
   localparam logic [AW1-1:0] REG_LO = AW1'(REG_BASE);
   localparam logic [AW1-1:0] REG_HI = AW1'(REG_BASE + 32);
   localparam logic [AW1-1:0] RX_LO  = AW1'(RXW_BASE);
   localparam logic [AW1-1:0] RX_HI  = AW1'(RXW_BASE + WIN_BYTES);
   localparam logic [AW1-1:0] TX_LO  = AW1'(TXW_BASE);
   localparam logic [AW1-1:0] TX_HI  = AW1'(TXW_BASE + WIN_BYTES);

   if (REG_BASE % 32 != 0) begin : g_bad_reg_base
      $error("dbgf_decode: REG_BASE must be 32-byte aligned");
   end
   if (WIN_BYTES % 4 != 0 || WIN_BYTES < 4) begin : g_bad_win
      $error("dbgf_decode: WIN_BYTES must be a positive multiple of 4");
   end
   if (RXW_BASE % 4 != 0 || TXW_BASE % 4 != 0) begin : g_bad_win_base
      $error("dbgf_decode: window bases must be word aligned");
   end
   if (REG_BASE + 32 > (1 << ADDR_W) || RXW_BASE + WIN_BYTES > (1 << ADDR_W)
       || TXW_BASE + WIN_BYTES > (1 << ADDR_W)) begin : g_bad_span
      $error("dbgf_decode: a region does not fit in ADDR_W");
   end

   logic [AW1-1:0] a_ext;
   logic [4:0]     roff;
   logic           in_reg, in_rx, in_tx;

   assign a_ext  = {1'b0, addr_i};
   assign roff   = addr_i[4:0] - REG_LO[4:0];
   assign in_reg = (a_ext >= REG_LO) && (a_ext < REG_HI);
   assign in_rx  = (a_ext >= RX_LO) && (a_ext < RX_HI);
   assign in_tx  = (a_ext >= TX_LO) && (a_ext < TX_HI);

   always_comb begin
      kind_o = AK_NONE;
      if (addr_i[1:0] == 2'b00) begin
         if (in_reg) begin
            unique case (roff)
               OFF_CTRL: kind_o = AK_CTRL;
               OFF_RXB:  kind_o = AK_RXB;
               OFF_TXB:  kind_o = AK_TXB;
               OFF_STAT: kind_o = AK_STAT;
               default:  kind_o = AK_NONE;
            endcase
         end else if (win_en_i && in_rx) begin
            kind_o = AK_RXW;
         end else if (win_en_i && in_tx) begin
            kind_o = AK_TXW;
         end
      end
   end

endmodule

// File: rtl/dbgf_byte_fifo.sv
module dbgf_byte_fifo #(
   parameter int DEPTH    = 1024,
   parameter int WR_LANES = 1,
   parameter int RD_LANES = 4,
   localparam int PW      = $clog2(DEPTH),
   localparam int CNT_W   = PW + 1,
   localparam int WNW     = $clog2(WR_LANES + 1),
   localparam int RNW     = $clog2(RD_LANES + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    flush_i,
   input  logic [WNW-1:0]          wr_n_i,     // bytes offered, lane 0 first
   input  logic [WR_LANES*8-1:0]   wr_data_i,
   input  logic [RNW-1:0]          rd_n_i,     // bytes requested
   output logic [RD_LANES*8-1:0]   rd_data_o,  // lane i = i-th oldest byte, 0 if absent
   output logic [CNT_W-1:0]        count_o
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("dbgf_byte_fifo: DEPTH must be a power of two of at least 2");
   end
   if (WR_LANES < 1 || RD_LANES < 1 || WR_LANES > DEPTH || RD_LANES > DEPTH) begin : g_bad_lanes
      $error("dbgf_byte_fifo: lane counts must lie in 1..DEPTH");
   end

   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

   logic [7:0]        mem [DEPTH];
   logic [PW-1:0]     wp, rp;
   logic [CNT_W-1:0]  cnt, room, wr_req, rd_req, wr_acc, rd_acc;

   assign room   = FULL - cnt;
   assign wr_req = CNT_W'(wr_n_i);
   assign rd_req = CNT_W'(rd_n_i);
   assign wr_acc = (wr_req > room) ? room : wr_req;
   assign rd_acc = (rd_req > cnt)  ? cnt  : rd_req;
   assign count_o = cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (flush_i) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         wp  <= wp + PW'(wr_acc);
         rp  <= rp + PW'(rd_acc);
         cnt <= cnt + wr_acc - rd_acc;
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < WR_LANES; i++) begin
         if (!flush_i && (CNT_W'(i) < wr_acc)) begin
            mem[wp + PW'(i)] <= wr_data_i[i*8 +: 8];
         end
      end
   end

   for (genvar g = 0; g < RD_LANES; g++) begin : g_rd_lane
      logic [PW-1:0] idx;
      assign idx = rp + PW'(g);
      assign rd_data_o[g*8 +: 8] = (CNT_W'(g) < cnt) ? mem[idx] : 8'h00;
   end

   // R11: fill level stays within the storage
   p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= FULL);

   // R11: a full FIFO with no pop keeps its level whatever is pushed
   p_full_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush_i && cnt == FULL && rd_n_i == '0) |=> cnt == FULL);

   // R10: an empty FIFO with no push stays empty whatever is popped
   p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush_i && cnt == '0 && wr_n_i == '0) |=> cnt == '0);

   // R7: flush leaves nothing behind
   p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> cnt == '0);

endmodule

// File: rtl/dbg_fifo_regif.sv
module dbg_fifo_regif
   import dbgf_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DEPTH     = 1024,
   parameter int REG_BASE  = 'h1000,
   parameter int RXW_BASE  = 'h0000,
   parameter int TXW_BASE  = 'h0800,
   parameter int WIN_BYTES = 1024,
   parameter int CTRL_RST  = 'h01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [31:0]       wdata_i,
   output logic              ack_o,
   output logic [31:0]       rdata_o,
   input  logic              h2c_push_i,
   input  logic [7:0]        h2c_byte_i,
   input  logic              c2h_pop_i,
   output logic [7:0]        c2h_byte_o
);

   localparam int CNT_W = $clog2(DEPTH) + 1;
   localparam int WB    = WORD_BYTES;
   localparam int WNW   = $clog2(WB + 1);

   if (CNT_W > CNT_FW) begin : g_bad_cnt
      $error("dbg_fifo_regif: DEPTH too large for the status count fields");
   end
   if (CTRL_RST < 0 || CTRL_RST >= (1 << CTRL_W)) begin : g_bad_rst
      $error("dbg_fifo_regif: CTRL_RST does not fit the control field");
   end

   acc_kind_e          kind;
   logic [CTRL_W-1:0]  ctrl_q;
   logic               rd_acc, wr_acc;

   logic [WNW-1:0]     h2c_rd_n, c2h_wr_n;
   logic [0:0]         h2c_wr_n, c2h_rd_n;
   logic [WB*8-1:0]    h2c_rd_data, c2h_wr_data, word_lanes;
   logic [7:0]         c2h_rd_data;
   logic [CNT_W-1:0]   h2c_cnt, c2h_cnt;
   logic               h2c_flush, c2h_flush;
   logic [31:0]        word_rd, rdata_d;

   dbgf_decode #(
      .ADDR_W   (ADDR_W),
      .REG_BASE (REG_BASE),
      .RXW_BASE (RXW_BASE),
      .TXW_BASE (TXW_BASE),
      .WIN_BYTES(WIN_BYTES)
   ) u_dec (
      .addr_i  (addr_i),
      .win_en_i(ctrl_q[EN_BIT]),
      .kind_o  (kind)
   );

   assign rd_acc = req_i && !we_i;
   assign wr_acc = req_i &&  we_i;

   // word <-> lane mapping: lane 0 (first byte) sits in the top byte of the word
   for (genvar g = 0; g < WB; g++) begin : g_word_map
      assign word_lanes[g*8 +: 8]          = wdata_i[31 - 8*g -: 8];
      assign word_rd[31 - 8*g -: 8]        = h2c_rd_data[g*8 +: 8];
   end

   // host-to-console path: host writes single bytes, console reads bytes or words
   assign h2c_wr_n  = h2c_push_i;
   assign h2c_rd_n  = (rd_acc && kind == AK_RXW) ? WNW'(WB) :
                      (rd_acc && kind == AK_RXB) ? WNW'(1)  : '0;
   assign h2c_flush = wr_acc && (kind == AK_STAT) && wdata_i[FLUSH_H2C];

   dbgf_byte_fifo #(
      .DEPTH   (DEPTH),
      .WR_LANES(1),
      .RD_LANES(WB)
   ) u_h2c (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush_i  (h2c_flush),
      .wr_n_i   (h2c_wr_n),
      .wr_data_i(h2c_byte_i),
      .rd_n_i   (h2c_rd_n),
      .rd_data_o(h2c_rd_data),
      .count_o  (h2c_cnt)
   );

   // console-to-host path: console writes bytes or words, host reads single bytes
   assign c2h_wr_n    = (wr_acc && kind == AK_TXW) ? WNW'(WB) :
                        (wr_acc && kind == AK_TXB) ? WNW'(1)  : '0;
   assign c2h_wr_data = (kind == AK_TXW) ? word_lanes : {{(WB-1)*8{1'b0}}, wdata_i[7:0]};
   assign c2h_rd_n    = c2h_pop_i;
   assign c2h_flush   = wr_acc && (kind == AK_STAT) && wdata_i[FLUSH_C2H];

   dbgf_byte_fifo #(
      .DEPTH   (DEPTH),
      .WR_LANES(WB),
      .RD_LANES(1)
   ) u_c2h (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush_i  (c2h_flush),
      .wr_n_i   (c2h_wr_n),
      .wr_data_i(c2h_wr_data),
      .rd_n_i   (c2h_rd_n),
      .rd_data_o(c2h_rd_data),
      .count_o  (c2h_cnt)
   );

   assign c2h_byte_o = c2h_rd_data;

   // read mux
   always_comb begin
      rdata_d = '0;
      if (rd_acc) begin
         unique case (kind)
            AK_CTRL: rdata_d = {{(32-CTRL_W){1'b0}}, ctrl_q};
            AK_RXB:  rdata_d = {24'h0, h2c_rd_data[7:0]};
            AK_STAT: rdata_d = {10'h0, CNT_FW'(c2h_cnt), CNT_FW'(h2c_cnt)};
            AK_RXW:  rdata_d = word_rd;
            default: rdata_d = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= CTRL_W'(CTRL_RST);
         ack_o   <= 1'b0;
         rdata_o <= '0;
      end else begin
         ack_o   <= req_i;
         rdata_o <= rdata_d;
         if (wr_acc && kind == AK_CTRL) begin
            ctrl_q <= wdata_i[CTRL_W-1:0];
         end
      end
   end

   // R1: every strobe is answered in the following cycle, and only then
   p_ack_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |=> ack_o);
   p_ack_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> !ack_o);

   // R2: control read keeps reserved bits clear
   p_ctrl_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && kind == AK_CTRL) |=> rdata_o[31:CTRL_W] == '0);

   // R4: byte read of a non-empty FIFO removes exactly one byte
   p_byte_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && kind == AK_RXB && h2c_cnt != '0 && !h2c_push_i)
      |=> h2c_cnt == $past(h2c_cnt) - CNT_W'(1));

   // R6: status read keeps its reserved top bits clear
   p_stat_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && kind == AK_STAT) |=> rdata_o[31:22] == '0);

   // R9: a word write with room for four bytes adds four bytes
   p_word_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && kind == AK_TXW && !c2h_pop_i && c2h_cnt <= CNT_W'(DEPTH - WB))
      |=> c2h_cnt == $past(c2h_cnt) + CNT_W'(WB));

endmodule

// File: tb/tb_dbg_fifo_regif.sv
module tb_dbg_fifo_regif;

   localparam int DEP      = 16;
   localparam int AW       = 16;
   localparam logic [15:0] A_CTRL = 16'h1000;
   localparam logic [15:0] A_RXB  = 16'h1008;
   localparam logic [15:0] A_TXB  = 16'h100C;
   localparam logic [15:0] A_STAT = 16'h1010;
   localparam logic [15:0] A_RXW  = 16'h0000;
   localparam logic [15:0] A_TXW  = 16'h0800;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0, we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0]   wdata = '0;
   logic          ack;
   logic [31:0]   rdata;
   logic          h2c_push = 1'b0;
   logic [7:0]    h2c_byte = '0;
   logic          c2h_pop = 1'b0;
   logic [7:0]    c2h_byte;

   int checks = 0;
   int fails  = 0;

   logic [7:0] qh[$];   // host-to-console model
   logic [7:0] qc[$];   // console-to-host model

   always #10 clk = ~clk;

   dbg_fifo_regif #(.ADDR_W(AW), .DEPTH(DEP)) dut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
      .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata),
      .h2c_push_i(h2c_push), .h2c_byte_i(h2c_byte),
      .c2h_pop_i(c2h_pop), .c2h_byte_o(c2h_byte)
   );

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %08h expected %08h", rq, act, exp);
      end
   endtask

   task automatic bus(input logic w, input logic [15:0] a, input logic [31:0] d,
                      output logic [31:0] r);
      @(negedge clk);
      req = 1'b1; we = w; addr = a; wdata = d;
      @(negedge clk);
      req = 1'b0; we = 1'b0;
      chk("R1 ack", {31'h0, ack}, 32'h1);
      r = rdata;
   endtask

   function automatic logic [31:0] stat_exp();
      return {10'h0, 11'(qc.size()), 11'(qh.size())};
   endfunction

   task automatic hpush(input logic [7:0] b);
      @(negedge clk);
      h2c_push = 1'b1; h2c_byte = b;
      @(negedge clk);
      h2c_push = 1'b0;
      if (qh.size() < DEP) qh.push_back(b);
   endtask

   task automatic hpop();
      logic [7:0] e;
      @(negedge clk);
      e = (qc.size() > 0) ? qc[0] : 8'h00;
      chk("R12 host byte", {24'h0, c2h_byte}, {24'h0, e});
      c2h_pop = 1'b1;
      @(negedge clk);
      c2h_pop = 1'b0;
      if (qc.size() > 0) void'(qc.pop_front());
   endtask

   function automatic logic [31:0] model_word_pop();
      logic [31:0] w = '0;
      for (int i = 0; i < 4; i++) begin
         logic [7:0] b;
         b = (qh.size() > 0) ? qh.pop_front() : 8'h00;
         w = {w[23:0], b};
      end
      return w;
   endfunction

   task automatic model_word_push(input logic [31:0] w);
      for (int i = 0; i < 4; i++)
         if (qc.size() < DEP) qc.push_back(w[31 - 8*i -: 8]);
   endtask

   task automatic flush_all();
      logic [31:0] r;
      bus(1'b1, A_STAT, 32'h00C0_0000, r);
      qh.delete(); qc.delete();
      bus(1'b0, A_STAT, 32'h0, r);
      chk("R7 flush both", r, 32'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] r, e;
      repeat (3) @(negedge clk);
      chk("R1 ack idle in reset", {31'h0, ack}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 empty host byte after reset", {24'h0, c2h_byte}, 32'h0);

      // R2 reset value, write/readback, upper bits
      bus(1'b0, A_CTRL, 32'h0, r);
      chk("R2 ctrl reset", r, 32'h0000_0001);
      bus(1'b1, A_CTRL, 32'hFFFF_FFFF, r);
      bus(1'b0, A_CTRL, 32'h0, r);
      chk("R2 ctrl all ones", r, 32'h0000_003F);
      bus(1'b1, A_CTRL, 32'h0000_0001, r);
      bus(1'b0, A_STAT, 32'h0, r);
      chk("R6 status after reset", r, 32'h0);

      // R3: windows closed while the enable bit is 0
      for (int i = 0; i < 3; i++) hpush(8'(8'h40 + i));
      bus(1'b0, A_RXW, 32'h0, r);
      chk("R3 closed read window returns 0", r, 32'h0);
      bus(1'b1, A_TXW, 32'h1122_3344, r);
      bus(1'b0, A_STAT, 32'h0, r);
      chk("R3 closed windows touch no FIFO", r, stat_exp());

      bus(1'b1, A_CTRL, 32'h0000_0021, r);

      // R5 / R1: non-pop reads and ignored writes
      bus(1'b0, A_TXB, 32'h0, r);
      chk("R5 tx byte reg reads 0", r, 32'h0);
      bus(1'b0, A_TXW, 32'h0, r);
      chk("R1 write window reads 0", r, 32'h0);
      bus(1'b0, 16'h1004, 32'h0, r);
      chk("R1 unmapped reads 0", r, 32'h0);
      bus(1'b0, 16'h0001, 32'h0, r);
      chk("R1 unaligned reads 0", r, 32'h0);
      bus(1'b1, A_RXB, 32'hFF, r);
      bus(1'b0, A_STAT, 32'h0, r);
      chk("R1 no state change", r, stat_exp());

      // R7: zero bits flush nothing, single bits flush one side
      bus(1'b1, A_TXB, 32'h0000_0077, r); qc.push_back(8'h77);
      bus(1'b1, A_STAT, 32'hFF3F_FFFF, r);
      bus(1'b0, A_STAT, 32'h0, r);
      chk("R7 zero flush bits no effect", r, stat_exp());
      bus(1'b1, A_STAT, 32'h0040_0000, r); qh.delete();
      bus(1'b0, A_STAT, 32'h0, r);
      chk("R7 flush h2c only", r, stat_exp());
      bus(1'b1, A_STAT, 32'h0080_0000, r); qc.delete();
      bus(1'b0, A_STAT, 32'h0, r);
      chk("R7 flush c2h only", r, stat_exp());

      // host-to-console sweep over every fill level, and one past full
      for (int n = 0; n <= DEP + 1; n++) begin
         int k = 0;
         flush_all();
         for (int i = 0; i < n; i++) hpush(8'(n * 17 + i + 1));
         bus(1'b0, A_STAT, 32'h0, r);
         chk("R11 R12 h2c count after host pushes", r, stat_exp());
         while (qh.size() > 0) begin
            if (k == 0 && (n % 2) == 1) begin
               bus(1'b0, A_RXB, 32'h0, r);
               e = {24'h0, qh.pop_front()};
               chk("R4 byte pop", r, e);
            end else begin
               bus(1'b0, 16'(A_RXW + ((k * 132) % 1024)), 32'h0, r);
               e = model_word_pop();
               chk("R8 R10 word pop", r, e);
            end
            k++;
            bus(1'b0, A_STAT, 32'h0, r);
            chk("R6 status during drain", r, stat_exp());
         end
         bus(1'b0, A_RXW, 32'h0, r);
         chk("R10 empty word pop", r, 32'h0);
         bus(1'b0, A_RXB, 32'h0, r);
         chk("R10 empty byte pop", r, 32'h0);
      end

      // console-to-host sweep: word writes across and beyond full
      for (int n = 0; n <= 5; n++) begin
         flush_all();
         for (int j = 0; j < n; j++) begin
            e = {8'(n*16 + j*4), 8'(n*16 + j*4 + 1), 8'(n*16 + j*4 + 2), 8'(n*16 + j*4 + 3)};
            bus(1'b1, 16'(A_TXW + j * 4), e, r);
            model_word_push(e);
         end
         e = 32'hFFFF_FF00 | 32'(n + 8'hC0);
         bus(1'b1, A_TXB, e, r);
         if (qc.size() < DEP) qc.push_back(e[7:0]);
         bus(1'b0, A_STAT, 32'h0, r);
         chk("R5 R9 R11 c2h count", r, stat_exp());
         for (int i = 0; i <= DEP; i++) hpop();
         bus(1'b0, A_STAT, 32'h0, r);
         chk("R12 c2h drained", r, stat_exp());
      end

      // word write into partially free space keeps leading bytes
      flush_all();
      for (int j = 0; j < 3; j++) begin
         bus(1'b1, A_TXW, 32'h0102_0304 + 32'(j) * 32'h1010_1010, r);
         model_word_push(32'h0102_0304 + 32'(j) * 32'h1010_1010);
      end
      bus(1'b1, A_TXB, 32'hAA, r); qc.push_back(8'hAA);
      bus(1'b1, A_TXB, 32'hBB, r); qc.push_back(8'hBB);
      bus(1'b1, A_TXW, 32'hC1C2_C3C4, r); model_word_push(32'hC1C2_C3C4);
      bus(1'b0, A_STAT, 32'h0, r);
      chk("R11 partial word write count", r, stat_exp());
      for (int i = 0; i <= DEP; i++) hpop();

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule